// File: doc/BRIEF.md
# Oscillator Frequency Ratio Meter

This block measures two free-running ring-style oscillators against the system clock and reports the ratio of their frequencies. Temperature and supply changes scale every delay on a die by roughly the same factor; a swing of about 30 °C moves absolute delay by around 5%. A ratio of two loop frequencies therefore cancels most of that drift, while the raw counts of each loop swing with it. The block counts rising edges of each loop over a programmable window of reference-clock cycles. Windows of tens of thousands of cycles give a resolution of a few hundred parts per million.

Loop A is measured first and loop B second, never both at once. Two loops running side by side at nearby frequencies tend to pull into lock, and that would drive the ratio toward exactly one. Each oscillator input passes through a two-flop synchronizer and a rising-edge detector before its saturating counter. Once both windows have closed, a sequential restoring divider forms count A × 2^FRAC_W / count B as an unsigned fixed-point value.

The result is an output stream with a valid/ready handshake. While `res_valid` is high and `res_ready` is low, every result pin holds its value. The result is consumed in the cycle where both are high, and the block returns to idle after that edge. A start strobe is taken only in idle.

Top module: `freq_ratio_meter`

## Requirements
- R1: While reset is asserted and directly after it, `busy` and `res_valid` are low.
- R2: `start` is accepted only while idle. `busy` goes high on the next cycle and stays high until the result has been consumed. A `start` during a measurement, a division or a pending result has no effect.
- R3: For a gate length G (a value of 0 counts as 1), loop A is counted during the G cycles that follow the accepting edge, and loop B during the G cycles after that. A rising edge is counted when the input is first sampled high at clock edge k after being low at edge k-1, and the window covers edge k+2.
- R4: Edges of loop B are never added to count A, and edges of loop A are never added to count B.
- R5: Each count saturates at 2^CNT_W-1 and never wraps.
- R6: When count B is nonzero, `res_ratio` equals floor(count A × 2^FRAC_W / count B).
- R7: When count B is zero, `res_div0` is 1 and `res_ratio` is 0.
- R8: `res_valid` rises exactly 2G + CNT_W + FRAC_W + 1 cycles after the accepting edge.
- R9: While `res_valid` is high and `res_ready` is low, all result outputs hold stable. When both are high, the block is idle on the next cycle.
- R10: The gate length is captured at the accepting edge. Changes to `gate_len` later in the run do not alter that run's windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_a | input | 1 | First loop oscillator, asynchronous |
| osc_b | input | 1 | Second loop oscillator, asynchronous |
| start | input | 1 | Begin a measurement (taken only when idle) |
| gate_len | input | GATE_W | Window length in reference cycles |
| busy | output | 1 | High from acceptance until the result is consumed |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_ratio | output | CNT_W+FRAC_W | Unsigned ratio with FRAC_W fraction bits |
| res_cnt_a | output | CNT_W | Edge count of loop A |
| res_cnt_b | output | CNT_W | Edge count of loop B |
| res_div0 | output | 1 | Count B was zero, ratio invalid |

## Verification
Saturation is the hardest state to reach from the ports. A counter saturates only when a window holds more loop edges than the counter can represent, and no edge can arrive faster than every second reference cycle. The bench therefore builds the block with a narrow count (8 bits) but a wide gate field. It runs a 1000-cycle window with loop A toggling on every reference cycle. A second difficult case is a start strobe together with a new gate length arriving in the middle of a run. The bench injects both while loop A is being counted, then checks that the run keeps the gate length captured at the accepting edge and keeps its original latency.

// File: rtl/frq_pkg.sv
package frq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOP_A,
    ST_LOOP_B,
    ST_PREP,
    ST_DIVIDE,
    ST_DONE
  } frq_state_t;
endpackage

// File: rtl/frq_edge_sync.sv
module frq_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic rise
);
  // stage 0 and 1 resolve metastability, stage 2 holds the previous level
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], osc_in};
  end

  assign rise = sh[1] & ~sh[2];

  // a detected rise is a single-cycle pulse
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/frq_divider.sv
module frq_divider #(
  parameter int CNT_W  = 24,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [CNT_W-1:0]        num,
  input  logic [CNT_W-1:0]        den,
  output logic [CNT_W+FRAC_W-1:0] quotient,
  output logic                    last
);
  localparam int QW = CNT_W + FRAC_W;
  localparam int IW = $clog2(QW + 1);

  logic [QW-1:0]    work;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] dsr;
  logic [IW-1:0]    iter;
  logic [CNT_W:0]   trial;
  logic [CNT_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem, work[QW-1]};
    diff  = trial - {1'b0, dsr};
    fits  = trial >= {1'b0, dsr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work <= '0;
      rem  <= '0;
      dsr  <= '0;
      iter <= '0;
    end else if (load) begin
      work <= {num, {FRAC_W{1'b0}}};
      rem  <= '0;
      dsr  <= den;
      iter <= IW'(QW);
    end else if (iter != '0) begin
      rem  <= fits ? diff[CNT_W-1:0] : trial[CNT_W-1:0];
      work <= {work[QW-2:0], fits};
      iter <= iter - 1'b1;
    end
  end

  assign quotient = work;
  assign last     = (iter == IW'(1));

  // partial remainder always stays below a nonzero divisor
  p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iter != '0 && dsr != '0) |-> rem < dsr);
endmodule

// File: rtl/freq_ratio_meter.sv
module freq_ratio_meter #(
  parameter int GATE_W = 24,
  parameter int CNT_W  = 24,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    osc_a,
  input  logic                    osc_b,
  input  logic                    start,
  input  logic [GATE_W-1:0]       gate_len,
  output logic                    busy,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [CNT_W+FRAC_W-1:0] res_ratio,
  output logic [CNT_W-1:0]        res_cnt_a,
  output logic [CNT_W-1:0]        res_cnt_b,
  output logic                    res_div0
);
  import frq_pkg::*;

  localparam int QW = CNT_W + FRAC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  frq_state_t        state;
  logic [GATE_W-1:0] timer;
  logic [GATE_W-1:0] gate_q;
  logic [CNT_W-1:0]  cnt_a;
  logic [CNT_W-1:0]  cnt_b;
  logic [1:0]        osc_vec;
  logic [1:0]        rise;
  logic              window_end;
  logic              div_last;
  logic [QW-1:0]     quotient;

  assign osc_vec = {osc_b, osc_a};

  for (genvar g = 0; g < 2; g++) begin : g_loop
    frq_edge_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .osc_in (osc_vec[g]),
      .rise   (rise[g])
    );
  end

  // a zero gate closes after one cycle, like a gate of one
  assign window_end = ({1'b0, timer} + (GATE_W+1)'(1)) >= {1'b0, gate_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      timer  <= '0;
      gate_q <= '0;
      cnt_a  <= '0;
      cnt_b  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          gate_q <= gate_len;
          timer  <= '0;
          cnt_a  <= '0;
          state  <= ST_LOOP_A;
        end
        ST_LOOP_A: begin
          if (rise[0] && cnt_a != CNT_MAX) cnt_a <= cnt_a + 1'b1;
          if (window_end) begin
            timer <= '0;
            cnt_b <= '0;
            state <= ST_LOOP_B;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_LOOP_B: begin
          if (rise[1] && cnt_b != CNT_MAX) cnt_b <= cnt_b + 1'b1;
          if (window_end) state <= ST_PREP;
          else            timer <= timer + 1'b1;
        end
        ST_PREP:   state <= ST_DIVIDE;
        ST_DIVIDE: if (div_last) state <= ST_DONE;
        ST_DONE:   if (res_ready) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  frq_divider #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state == ST_PREP),
    .num      (cnt_a),
    .den      (cnt_b),
    .quotient (quotient),
    .last     (div_last)
  );

  assign busy      = (state != ST_IDLE);
  assign res_valid = (state == ST_DONE);
  assign res_div0  = (cnt_b == '0);
  assign res_ratio = res_div0 ? '0 : quotient;
  assign res_cnt_a = cnt_a;
  assign res_cnt_b = cnt_b;

  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOP_A && cnt_a == CNT_MAX) |=> cnt_a == CNT_MAX);

  p_a_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOP_B) |=> $stable(cnt_a));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_ratio)
      && $stable(res_cnt_a) && $stable(res_cnt_b) && $stable(res_div0));

  p_gate_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(gate_q));

  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOP_B) |=> state != ST_LOOP_A);
endmodule

// File: tb/freq_ratio_meter_bench.sv
`timescale 1ns/1ps
module freq_ratio_meter_bench;
  localparam int GATE_W = 12;
  localparam int CNT_W  = 8;
  localparam int FRAC_W = 16;
  localparam int QW     = CNT_W + FRAC_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic osc_a = 0, osc_b = 0;
  logic start = 0;
  logic [GATE_W-1:0] gate_len = '0;
  logic busy, res_valid, res_div0;
  logic res_ready = 0;
  logic [QW-1:0] res_ratio;
  logic [CNT_W-1:0] res_cnt_a, res_cnt_b;

  int nchecks = 0, nerr = 0, cyc = 0;
  int half_a = 0, half_b = 0, ph_a = 0, ph_b = 0;

  always #2.5 clk = ~clk;

  freq_ratio_meter #(.GATE_W(GATE_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_freq_ratio_meter (
    .clk(clk), .rst_n(rst_n), .osc_a(osc_a), .osc_b(osc_b), .start(start),
    .gate_len(gate_len), .busy(busy), .res_valid(res_valid), .res_ready(res_ready),
    .res_ratio(res_ratio), .res_cnt_a(res_cnt_a), .res_cnt_b(res_cnt_b), .res_div0(res_div0)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // oscillators toggle on falling clock edges, half period in cycles, 0 = stopped
  always @(negedge clk) begin
    if (half_a == 0) begin osc_a <= 0; ph_a <= 0; end
    else if (ph_a + 1 >= half_a) begin osc_a <= ~osc_a; ph_a <= 0; end
    else ph_a <= ph_a + 1;
    if (half_b == 0) begin osc_b <= 0; ph_b <= 0; end
    else if (ph_b + 1 >= half_b) begin osc_b <= ~osc_b; ph_b <= 0; end
    else ph_b <= ph_b + 1;
  end

  // behavioural reference: 0 idle, 1 loop A, 2 loop B, 3 dividing, 4 result
  int m_st = 0, m_timer = 0, m_gate = 0, m_ca = 0, m_cb = 0, m_div = 0;
  bit ha1, ha2, ha3, hb1, hb2, hb3;

  always @(posedge clk) begin
    bit ea, eb;
    if (!rst_n) begin
      m_st = 0; m_timer = 0; m_gate = 0; m_ca = 0; m_cb = 0; m_div = 0;
      ha1 = 0; ha2 = 0; ha3 = 0; hb1 = 0; hb2 = 0; hb3 = 0;
    end else begin
      ea = ha2 && !ha3;
      eb = hb2 && !hb3;
      case (m_st)
        0: if (start) begin m_gate = gate_len; m_timer = 0; m_ca = 0; m_st = 1; end
        1: begin
          if (ea && m_ca < CMAX) m_ca++;
          if (m_timer + 1 >= m_gate) begin m_st = 2; m_timer = 0; m_cb = 0; end
          else m_timer++;
        end
        2: begin
          if (eb && m_cb < CMAX) m_cb++;
          if (m_timer + 1 >= m_gate) begin m_st = 3; m_div = 0; end
          else m_timer++;
        end
        3: begin m_div++; if (m_div == QW + 1) m_st = 4; end
        4: if (res_ready) m_st = 0;
        default: m_st = 0;
      endcase
      ha3 = ha2; ha2 = ha1; ha1 = osc_a;
      hb3 = hb2; hb2 = hb1; hb1 = osc_b;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_st != 0), "R2 busy", busy, m_st != 0);
      chk(res_valid == (m_st == 4), "R8 valid timing", res_valid, m_st == 4);
      if (m_st == 4) begin
        longint er;
        er = (m_cb == 0) ? 0 : ((longint'(m_ca) << FRAC_W) / m_cb);
        chk(res_cnt_a == m_ca, "R3 count A", res_cnt_a, m_ca);
        chk(res_cnt_b == m_cb, "R3 count B", res_cnt_b, m_cb);
        chk(res_div0 == (m_cb == 0), "R7 div0 flag", res_div0, m_cb == 0);
        chk(res_ratio == er, "R6 ratio", res_ratio, er);
      end
    end
  end

  task automatic show_summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
      show_summary();
      $finish;
    end
  end

  int lat;
  logic [QW-1:0] cap_ratio;
  logic [CNT_W-1:0] cap_a, cap_b;
  logic cap_div0;

  task automatic do_run(input int gate, input int pa, input int pb, input int hold, input bit poke);
    int g;
    g = (gate == 0) ? 1 : gate;
    half_a = pa; half_b = pb;
    repeat (8) @(negedge clk);
    start = 1; gate_len = GATE_W'(gate);
    @(negedge clk);
    start = 0; lat = 0;
    while (!res_valid) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 5) begin start = 1; gate_len = GATE_W'(3); end
      else if (poke && lat == 6) begin start = 0; gate_len = GATE_W'(gate); end
    end
    chk(lat == 2 * g + QW + 1, poke ? "R10 latency with poke" : "R8 latency", lat, 2 * g + QW + 1);
    cap_ratio = res_ratio; cap_a = res_cnt_a; cap_b = res_cnt_b; cap_div0 = res_div0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(res_valid && res_ratio == cap_ratio && res_cnt_a == cap_a && res_cnt_b == cap_b
          && res_div0 == cap_div0, "R9 hold", res_ratio, cap_ratio);
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    chk(!busy && !res_valid, "R9 consumed", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !res_valid, "R1 in reset", {busy, res_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !res_valid, "R1 after reset", {busy, res_valid}, 0);

    do_run(200, 2, 3, 0, 0);
    chk(res_cnt_b != 0 && cap_ratio == ((longint'(cap_a) << FRAC_W) / cap_b), "R6 A faster", cap_ratio, 0);
    do_run(150, 4, 2, 12, 0);
    chk(cap_ratio < (1 << FRAC_W), "R6 A slower below one", cap_ratio, 1 << FRAC_W);
    do_run(1000, 1, 5, 0, 0);
    chk(cap_a == CMAX, "R5 saturation A", cap_a, CMAX);
    do_run(100, 0, 2, 0, 0);
    chk(cap_a == 0 && cap_ratio == 0, "R4 only loop A counted", cap_a, 0);
    do_run(100, 3, 0, 0, 0);
    chk(cap_div0 && cap_ratio == 0, "R7 zero divisor", cap_ratio, 0);
    do_run(0, 1, 1, 0, 0);
    chk(cap_a <= 1 && cap_b <= 1, "R3 zero gate one cycle", cap_a, 1);
    do_run(120, 2, 5, 3, 1);
    chk(cap_a >= 25 && cap_a <= 31, "R2 start during run ignored", cap_a, 30);

    repeat (4) @(negedge clk);
    show_summary();
    $finish;
  end
endmodule